// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block picks one winner among N requesters and always favours the requester that has waited longest since its last committed grant. Its priority state is a set of pairwise ordering bits, one for each unordered pair of requesters. Each bit records which of the two requesters currently wins against the other.

The grant is combinational from the request vector and the stored state, so a client can see the winner in the same cycle it raises its request. The grant is committed by holding the enable high on a clock edge. On that edge the winner is moved behind every other requester. This is done by rewriting only the pair bits that involve the winner: the winner's row is cleared and its column is set. Nothing else in the matrix changes.

Top module: `lrs_matrix_arb`

## Requirements
- R1: The grant vector has at most one bit set, and a grant bit is set only where the matching request bit is set.
- R2: An all-zero request vector gives an all-zero grant, and a clock edge in that cycle leaves the priority state unchanged even with the enable high.
- R3: Whenever at least one request bit is set, exactly one grant bit is set.
- R4: After a synchronous active-high reset, priority is a fixed total order with lower indices ahead of higher ones. With every requester active, requester 0 is granted (grant vector 0b...00001).
- R5: The grant goes to the active requester that has gone longest without a committed grant. Ties from the reset order are broken toward the lower index.
- R6: The priority state changes only on a rising clock edge where the enable is high and some grant bit is set. With the enable low, the grant seen in the following cycles is the same as if that cycle had not occurred.
- R7: After a committed grant to requester k, requester k is behind every other requester. If the same request vector with two or more bits set is presented again, the grant goes to a different requester.
- R8: With three requesters active and order 2 ahead of 1 ahead of 0, successive committed grants go to 2, then 1, then 0, then 2. If only requesters 0 and 2 are active and 2 was served after 0, requester 0 wins.
- R9: The requester count N is a parameter from 2 to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to the index order |
| req | input | N | Request vector, bit i for requester i |
| en | input | 1 | Commit the current grant into the priority state on this edge |
| gnt | output | N | One-hot grant vector, all zero when nothing requests |

## Verification
The bench drives the directed three-requester sequence in which a design that swaps the row and column update would repeat a winner or serve requesters in the wrong order. It also drives the 0-and-2 case, where an inverted mirror bit for a non-stored pair would pick requester 2. Cycles with the enable low come between commits, so a design that updates without the enable would shift the later grants. Cycles with the enable high and no request are also included, so a design that updates on such a cycle would corrupt the order. Random request and enable patterns are compared against a timestamp model of last-served order, which catches a wrong reset order, a lost mutual exclusion, or a grant given to an idle requester.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  // flat position of pair (a,b), a<b, in the triangular store of an n-input matrix
  function automatic int pair_pos(input int a, input int b, input int n);
    return a * n - (a * (a + 1)) / 2 + (b - a - 1);
  endfunction

  function automatic int pair_count(input int n);
    return (n * (n - 1)) / 2;
  endfunction
endpackage

// File: rtl/lrs_prio_state.sv
module lrs_prio_state
  import lrs_pkg::*;
#(
  parameter int N = 4,
  localparam int NP = pair_count(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [N-1:0]  win,
  output logic [NP-1:0] ahead
);
  // ahead[pair_pos(a,b)] = 1 means a beats b (a<b)
  for (genvar a = 0; a < N - 1; a++) begin : g_row
    for (genvar b = a + 1; b < N; b++) begin : g_col
      localparam int P = pair_pos(a, b, N);
      always_ff @(posedge clk) begin
        if (rst) begin
          ahead[P] <= 1'b1;
        end else if (upd) begin
          if (win[a])      ahead[P] <= 1'b0;  // row of winner cleared
          else if (win[b]) ahead[P] <= 1'b1;  // column of winner set
        end
      end
    end
  end

  // R6: state holds when no commit
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(ahead));
endmodule

// File: rtl/lrs_grant_logic.sv
module lrs_grant_logic
  import lrs_pkg::*;
#(
  parameter int N = 4,
  localparam int NP = pair_count(N)
) (
  input  logic [N-1:0]  req,
  input  logic [NP-1:0] ahead,
  output logic [N-1:0]  gnt
);
  for (genvar i = 0; i < N; i++) begin : g_req
    logic [N-1:0] blocker;
    for (genvar j = 0; j < N; j++) begin : g_other
      if (j < i) begin : g_lo
        assign blocker[j] = req[j] & ahead[pair_pos(j, i, N)];
      end else if (j > i) begin : g_hi
        assign blocker[j] = req[j] & ~ahead[pair_pos(i, j, N)];
      end else begin : g_self
        assign blocker[j] = 1'b0;
      end
    end
    assign gnt[i] = req[i] & ~|blocker;
  end
endmodule

// File: rtl/lrs_matrix_arb.sv
module lrs_matrix_arb
  import lrs_pkg::*;
#(
  parameter int N = 4,
  localparam int NP = pair_count(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] gnt
);
  if (N < 2 || N > 8) begin : g_bad_n
    $error("lrs_matrix_arb: N must be 2..8 (R9)");
  end

  logic [NP-1:0] ahead;
  logic          upd;

  assign upd = en & (|gnt);

  lrs_prio_state #(.N(N)) u_state (
    .clk(clk), .rst(rst), .upd(upd), .win(gnt), .ahead(ahead)
  );

  lrs_grant_logic #(.N(N)) u_grant (
    .req(req), .ahead(ahead), .gnt(gnt)
  );

  assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (gnt == '0));

  assert_conserve_R3: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> ($countones(gnt) == 1));

  assert_demote_R7: assert property (@(posedge clk) disable iff (rst)
    (en && $countones(req) > 1) |=> ((req != $past(req)) || (gnt != $past(gnt))));
endmodule

// File: tb/sim_lrs_matrix_arb.sv
module sim_lrs_matrix_arb;
  localparam int N = 5;
  localparam time CLK_P = 20ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic         en  = 1'b0;
  logic [N-1:0] gnt;

  int compared = 0;
  int mismatched = 0;
  int unsigned stamp [N];
  int unsigned next_stamp;
  bit finished = 1'b0;

  lrs_matrix_arb #(.N(N)) u0 (.clk(clk), .rst(rst), .req(req), .en(en), .gnt(gnt));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [N-1:0] model_gnt(input logic [N-1:0] r);
    logic [N-1:0] g = '0;
    int best = -1;
    for (int i = 0; i < N; i++)
      if (r[i] && (best < 0 || stamp[i] < stamp[best])) best = i;
    if (best >= 0) g[best] = 1'b1;
    return g;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) stamp[i] = i;
    next_stamp = N;
  endtask

  task automatic check(input logic [N-1:0] got, input logic [N-1:0] exp, input string tag);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: gnt=%b expected=%b", tag, got, exp);
    end
  endtask

  // one cycle: drive, compare against model (and optional literal), commit in model
  task automatic step(input logic [N-1:0] r, input bit e, input string tag,
                      input bit use_lit = 1'b0, input logic [N-1:0] lit = '0);
    logic [N-1:0] exp;
    @(negedge clk);
    req = r;
    en  = e;
    #2;
    exp = model_gnt(r);
    if (use_lit) check(gnt, lit, tag);
    else         check(gnt, exp, tag);
    if (e && exp != '0)
      for (int i = 0; i < N; i++) if (exp[i]) stamp[i] = next_stamp++;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run hung");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    bit e;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R4: reset order, lowest index first
    step(5'b11111, 1'b0, "R4 reset all-request", 1'b1, 5'b00001);
    step(5'b11110, 1'b0, "R4 reset order 1 first", 1'b1, 5'b00010);
    // R2: no request, enable high, no change
    step(5'b00000, 1'b1, "R2 idle zero grant", 1'b1, 5'b00000);
    step(5'b11111, 1'b0, "R2 state kept after idle enable", 1'b1, 5'b00001);
    // R6: enable low does not commit
    step(5'b00011, 1'b0, "R6 no-commit cycle", 1'b1, 5'b00001);
    step(5'b00011, 1'b0, "R6 grant unchanged with enable low", 1'b1, 5'b00001);

    // build order 2 > 1 > 0 among the low three: serve 1 then 0
    step(5'b00010, 1'b1, "R5 serve 1 alone", 1'b1, 5'b00010);
    step(5'b00001, 1'b1, "R5 serve 0 alone", 1'b1, 5'b00001);
    // R8 directed sequence
    step(5'b00111, 1'b1, "R8 seq first 2", 1'b1, 5'b00100);
    step(5'b00111, 1'b1, "R8 seq then 1", 1'b1, 5'b00010);
    step(5'b00111, 1'b1, "R8 seq then 0", 1'b1, 5'b00001);
    step(5'b00111, 1'b1, "R8 seq then 2 again", 1'b1, 5'b00100);
    // R8: 2 served after 0, only 0 and 2 active -> 0
    step(5'b00101, 1'b0, "R8 pair 0 vs 2", 1'b1, 5'b00001);
    // R7: committed winner drops behind everyone
    step(5'b11000, 1'b1, "R7 grant 3", 1'b1, 5'b01000);
    step(5'b11000, 1'b1, "R7 repeat goes to 4", 1'b1, 5'b10000);
    step(5'b11000, 1'b0, "R7 back to 3", 1'b1, 5'b01000);

    // R4 again: reset mid-run restores index order
    @(negedge clk); rst = 1'b1; req = '0; en = 1'b0;
    @(negedge clk); rst = 1'b0;
    model_reset();
    step(5'b11100, 1'b0, "R4 re-reset order", 1'b1, 5'b00100);

    // R1 R3 R5 R6: random traffic against timestamp model
    for (int n = 0; n < 600; n++) begin
      r = N'($urandom());
      if (($urandom() % 8) == 0) r = '0;
      e = ($urandom() % 4) != 0;
      step(r, e, "R5 random LRS order");
      compared++;
      if (!((gnt & (gnt - 1'b1)) == '0 && (gnt & ~r) == '0 && ((r != '0) == (gnt != '0)))) begin
        mismatched++;
        $display("FAIL R1/R3 one-hot: gnt=%b req=%b", gnt, r);
      end
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule